// File: doc/BRIEF.md
# Load/store-multiple micro-op sequencer

This block sits in a decode stage and turns one block-transfer memory instruction into an ordered series of micro-operations, one per clock. The instruction enters on a valid/ready handshake. It carries a register list with one bit per architectural register, a base register index, and four flags: load versus store, ascending versus descending addresses, base writeback, and user-bank access. Each micro-op leaves on a second valid/ready handshake. It carries an opcode, a destination id, a source id, an address offset with a sign bit, several marking flags and a last-micro-op flag.

The base register is never updated before every memory transfer has been issued. On a writeback load, the final loaded value goes to a scratch register first. It is moved to its real destination only after the base update. A fault during any transfer therefore leaves the base register unchanged.

Back-pressure rules: `in_ready` is high only when no micro-op is outstanding, and an instruction is taken on a cycle where both `in_valid` and `in_ready` are high. A micro-op is handed off on a cycle where both `uop_valid` and `uop_ready` are high. While `uop_ready` is low, the micro-op outputs stay unchanged.

Top module: `blkxfer_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no micro-op is being offered. An instruction is taken when `in_valid` and `in_ready` are both high. While `uop_valid` is high and `uop_ready` is low, every micro-op output stays unchanged.
- R2: For a list with n > 0 set bits, the number of micro-ops handed off is 1 + n + w, where w is 2 for a writeback load, 1 for a writeback store and 0 without writeback.
- R3: An empty list produces exactly one micro-op (the base copy) with the last flag set, and no base update.
- R4: The first micro-op is always opcode 0 (add-immediate) with destination id 32 (scratch 0), the base index as source and an offset of 0.
- R5: Transfers follow in ascending register index. Each has source id 32. A load has opcode 2 with the register in dst; a store has opcode 3 with the data register in dst. Register ids 0–15 are architectural registers, 16–31 are the user-bank copies of registers 0–15, 32 is scratch 0 and 33 is scratch 1. For the k-th transfer (k from 0) of n, the offset is 4k with `uop_neg`=0 when ascending, and 4(n−k) with `uop_neg`=1 when descending.
- R6: With writeback and n > 0, one base update follows all transfers. It is opcode 0 when ascending or opcode 1 (subtract-immediate) when descending, with dst and src both equal to the base index and an offset of 4n.
- R7: On a writeback load, the final transfer is a load (opcode 2) into id 33. After the base update comes a move (opcode 4) from id 33 to the final register.
- R8: When the user flag is set and register 15 is not in the list, every transferred register id is its index plus 16.
- R9: When the user flag is set and register 15 is in the list (exception return), without writeback, the load of register 15 uses opcode 5 with dst 15 and `uop_nonspec`=1.
- R10: On an exception return with writeback, the final micro-op is opcode 6 with dst 15, src 33 and `uop_nonspec`=1.
- R11: A final move (opcode 4) into register 15 has `uop_ctrl`=1. It also has `uop_ret`=1 only when the base index is 13. No other micro-op asserts these flags.
- R12: `uop_last` is high on the final micro-op of an instruction and on no other micro-op. `in_ready` returns high in the cycle after that micro-op is handed off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction can be taken |
| in_list | input | 16 | Register list, bit i selects register i |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending addresses, 0 = descending |
| in_wb | input | 1 | Write the updated address back to the base |
| in_user | input | 1 | User-bank access or exception return |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_opc | output | 3 | Opcode 0..6 |
| uop_dst | output | 6 | Destination (or store data) register id |
| uop_src | output | 6 | Source register id |
| uop_imm | output | 7 | Offset magnitude |
| uop_neg | output | 1 | Offset is subtracted |
| uop_nonspec | output | 1 | Non-speculative, serialize after |
| uop_ctrl | output | 1 | Indirect control transfer |
| uop_ret | output | 1 | Return (stack-pop) transfer |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The assertions assume that the instruction fields hold defined values in the cycle `in_valid` is high and `in_ready` is high, since they are sampled only then. They also assume that the consumer may hold `uop_ready` low for any number of cycles. The stimulus drives fully defined instruction fields and drops `in_valid` right after acceptance. It stalls the micro-op stream with repeating ready patterns that always contain a high bit, so every sequence completes. The cases cover both directions, with and without writeback, user-bank remapping, both exception-return forms, a full list, an empty list, and final moves into register 15 with and without a stack base.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [2:0] {
    OP_ADDI  = 3'd0,
    OP_SUBI  = 3'd1,
    OP_LD    = 3'd2,
    OP_ST    = 3'd3,
    OP_MOV   = 3'd4,
    OP_RETLD = 3'd5,
    OP_RETMV = 3'd6
  } uop_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COPY,
    PH_XFER,
    PH_UPD,
    PH_MOVE
  } phase_e;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          single
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign single = ((vec & (vec - W'(1))) == '0);
endmodule

// File: rtl/blkxfer_uop_seq.sv
module blkxfer_uop_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int SP_IDX = 13,
  localparam int RW  = $clog2(NREG),
  localparam int IDW = RW + 2,
  localparam int CW  = $clog2(NREG + 1),
  localparam int IMW = CW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NREG-1:0] in_list,
  input  logic [RW-1:0]   in_base,
  input  logic            in_load,
  input  logic            in_up,
  input  logic            in_wb,
  input  logic            in_user,
  output logic            uop_valid,
  input  logic            uop_ready,
  output logic [2:0]      uop_opc,
  output logic [IDW-1:0]  uop_dst,
  output logic [IDW-1:0]  uop_src,
  output logic [IMW-1:0]  uop_imm,
  output logic            uop_neg,
  output logic            uop_nonspec,
  output logic            uop_ctrl,
  output logic            uop_ret,
  output logic            uop_last
);
  localparam logic [RW-1:0]  PC_IDX = RW'(NREG - 1);
  localparam logic [RW-1:0]  SP_REG = RW'(SP_IDX);
  localparam logic [IDW-1:0] S0_ID  = IDW'(2 * NREG);
  localparam logic [IDW-1:0] S1_ID  = IDW'(2 * NREG + 1);
  localparam logic [IDW-1:0] PC_ID  = IDW'(NREG - 1);
  localparam logic [IDW-1:0] BANK   = IDW'(NREG);

  phase_e          phase;
  logic [NREG-1:0] r_pend;
  logic [RW-1:0]   r_base;
  logic            r_load, r_up, r_wb, r_fu, r_er;
  logic [CW-1:0]   r_cnt, r_k;
  logic [RW-1:0]   r_lastr;

  logic [CW-1:0]   in_cnt;
  logic [RW-1:0]   cur_idx;
  logic            cur_final;
  logic [IDW-1:0]  cur_id, last_id, base_id;
  logic            hs;
  uop_op_e         op;

  blkxfer_popcnt #(.W(NREG)) u_cnt (
    .vec (in_list),
    .cnt (in_cnt)
  );

  blkxfer_lowbit #(.W(NREG)) u_low (
    .vec    (r_pend),
    .idx    (cur_idx),
    .single (cur_final)
  );

  assign base_id  = IDW'(r_base);
  assign cur_id   = IDW'(cur_idx) + (r_fu ? BANK : '0);
  assign last_id  = IDW'(r_lastr) + (r_fu ? BANK : '0);
  assign in_ready = (phase == PH_IDLE);
  assign hs       = uop_valid && uop_ready;
  assign uop_opc  = op;

  always_comb begin
    uop_valid   = (phase != PH_IDLE);
    op          = OP_ADDI;
    uop_dst     = '0;
    uop_src     = '0;
    uop_imm     = '0;
    uop_neg     = 1'b0;
    uop_nonspec = 1'b0;
    uop_ctrl    = 1'b0;
    uop_ret     = 1'b0;
    uop_last    = 1'b0;
    case (phase)
      PH_COPY: begin
        uop_dst  = S0_ID;
        uop_src  = base_id;
        uop_last = (r_cnt == '0);
      end
      PH_XFER: begin
        uop_src  = S0_ID;
        uop_imm  = r_up ? {r_k, 2'b00} : {r_cnt - r_k, 2'b00};
        uop_neg  = !r_up;
        uop_last = cur_final && !r_wb;
        if (!r_load) begin
          op      = OP_ST;
          uop_dst = cur_id;
        end else if (r_wb && cur_final) begin
          op      = OP_LD;
          uop_dst = S1_ID;
        end else if (r_er && cur_idx == PC_IDX) begin
          op          = OP_RETLD;
          uop_dst     = PC_ID;
          uop_nonspec = 1'b1;
        end else begin
          op      = OP_LD;
          uop_dst = cur_id;
        end
      end
      PH_UPD: begin
        op       = r_up ? OP_ADDI : OP_SUBI;
        uop_dst  = base_id;
        uop_src  = base_id;
        uop_imm  = {r_cnt, 2'b00};
        uop_last = !r_load;
      end
      PH_MOVE: begin
        uop_src  = S1_ID;
        uop_last = 1'b1;
        if (r_er && r_lastr == PC_IDX) begin
          op          = OP_RETMV;
          uop_dst     = PC_ID;
          uop_nonspec = 1'b1;
        end else begin
          op       = OP_MOV;
          uop_dst  = last_id;
          uop_ctrl = (r_lastr == PC_IDX);
          uop_ret  = (r_lastr == PC_IDX) && (r_base == SP_REG);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      r_pend  <= '0;
      r_base  <= '0;
      r_load  <= 1'b0;
      r_up    <= 1'b0;
      r_wb    <= 1'b0;
      r_fu    <= 1'b0;
      r_er    <= 1'b0;
      r_cnt   <= '0;
      r_k     <= '0;
      r_lastr <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (in_valid) begin
          r_pend <= in_list;
          r_base <= in_base;
          r_load <= in_load;
          r_up   <= in_up;
          r_wb   <= in_wb;
          r_fu   <= in_user && !in_list[NREG-1];
          r_er   <= in_user && in_list[NREG-1];
          r_cnt  <= in_cnt;
          r_k    <= '0;
          phase  <= PH_COPY;
        end
        PH_COPY: if (hs) phase <= (r_cnt == '0) ? PH_IDLE : PH_XFER;
        PH_XFER: if (hs) begin
          r_pend <= r_pend & (r_pend - NREG'(1));
          r_k    <= r_k + CW'(1);
          if (cur_final) begin
            r_lastr <= cur_idx;
            phase   <= r_wb ? PH_UPD : PH_IDLE;
          end
        end
        PH_UPD:  if (hs) phase <= r_load ? PH_MOVE : PH_IDLE;
        PH_MOVE: if (hs) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG),
  localparam int IDW = RW + 2,
  localparam int CW  = $clog2(NREG + 1),
  localparam int IMW = CW + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [NREG-1:0] in_list,
  input logic [RW-1:0]   in_base,
  input logic            in_load,
  input logic            in_wb,
  input logic            uop_valid,
  input logic            uop_ready,
  input logic [2:0]      uop_opc,
  input logic [IDW-1:0]  uop_dst,
  input logic [IDW-1:0]  uop_src,
  input logic [IMW-1:0]  uop_imm,
  input logic            uop_neg,
  input logic            uop_nonspec,
  input logic            uop_ctrl,
  input logic            uop_ret,
  input logic            uop_last
);
  logic          take, give;
  int            exp_n, seen;
  logic          base_done;
  logic [RW-1:0] base_q;

  assign take = in_valid && in_ready;
  assign give = uop_valid && uop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_n     <= 0;
      seen      <= 0;
      base_done <= 1'b0;
      base_q    <= '0;
    end else if (take) begin
      exp_n     <= ($countones(in_list) == 0) ? 1 :
                   1 + $countones(in_list) + (in_wb ? (in_load ? 2 : 1) : 0);
      seen      <= 0;
      base_done <= 1'b0;
      base_q    <= in_base;
    end else if (give) begin
      seen <= seen + 1;
      if ((uop_opc == 3'd0 || uop_opc == 3'd1) && uop_dst == IDW'(base_q))
        base_done <= 1'b1;
    end
  end

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !uop_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid &&
      $stable({uop_opc, uop_dst, uop_src, uop_imm, uop_neg, uop_nonspec,
               uop_ctrl, uop_ret, uop_last}));

  a_r4_first_copy: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> uop_valid && uop_opc == 3'd0 && uop_dst == IDW'(2 * NREG) &&
             uop_imm == '0 && uop_src == IDW'($past(in_base)));

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    give && uop_last |-> (seen + 1 == exp_n));

  a_r12_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    give && uop_last |=> in_ready);

  a_r6_base_after_xfers: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && (uop_opc == 3'd2 || uop_opc == 3'd3 || uop_opc == 3'd5)
      |-> !base_done);

  a_r9_nonspec_kind: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_nonspec |-> (uop_opc == 3'd5 || uop_opc == 3'd6));

  a_r11_ret_is_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ret |-> uop_ctrl && uop_opc == 3'd4 &&
      uop_dst == IDW'(NREG - 1));
endmodule

bind blkxfer_uop_seq blkxfer_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/sim_blkxfer_uop_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_uop_seq;
  typedef struct packed {
    logic [2:0] opc;
    logic [5:0] dst;
    logic [5:0] src;
    logic [6:0] imm;
    logic       neg;
    logic       ns;
    logic       ctrl;
    logic       ret;
    logic       last;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_list = '0;
  logic [3:0]  in_base = '0;
  logic        in_load = 1'b0, in_up = 1'b0, in_wb = 1'b0, in_user = 1'b0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [2:0]  uop_opc;
  logic [5:0]  uop_dst, uop_src;
  logic [6:0]  uop_imm;
  logic        uop_neg, uop_nonspec, uop_ctrl, uop_ret, uop_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blkxfer_uop_seq u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic rec_t mk(int opc, int dst, int src, int imm, bit neg,
                              bit ns, bit ctrl, bit ret, bit last);
    rec_t r;
    r.opc = 3'(opc); r.dst = 6'(dst); r.src = 6'(src); r.imm = 7'(imm);
    r.neg = neg; r.ns = ns; r.ctrl = ctrl; r.ret = ret; r.last = last;
    return r;
  endfunction

  // Reference model: expected micro-op list built from the requirements.
  task automatic build(ref rec_t q[$], input logic [15:0] list, input int base,
                       input bit ld, input bit up, input bit wb, input bit usr);
    int n = $countones(list);
    bit fu = usr && !list[15];
    bit er = usr && list[15];
    int k = 0;
    int lastr = 0;
    q.push_back(mk(0, 32, base, 0, 0, 0, 0, 0, n == 0));
    if (n == 0) return;
    for (int r = 0; r < 16; r++) begin
      if (list[r]) begin
        bit fin = (k == n - 1);
        int id = fu ? r + 16 : r;
        int imm = up ? 4 * k : 4 * (n - k);
        bit lst = fin && !wb;
        if (!ld)                 q.push_back(mk(3, id, 32, imm, !up, 0, 0, 0, lst));
        else if (wb && fin)      q.push_back(mk(2, 33, 32, imm, !up, 0, 0, 0, lst));
        else if (er && r == 15)  q.push_back(mk(5, 15, 32, imm, !up, 1, 0, 0, lst));
        else                     q.push_back(mk(2, id, 32, imm, !up, 0, 0, 0, lst));
        lastr = r;
        k++;
      end
    end
    if (wb) begin
      q.push_back(mk(up ? 0 : 1, base, base, 4 * n, 0, 0, 0, 0, !ld));
      if (ld) begin
        if (er && lastr == 15) q.push_back(mk(6, 15, 33, 0, 0, 1, 0, 0, 1));
        else q.push_back(mk(4, fu ? lastr + 16 : lastr, 33, 0, 0, 0,
                            lastr == 15, lastr == 15 && base == 13, 1));
      end
    end
  endtask

  task automatic run(input logic [15:0] list, input int base, input bit ld,
                     input bit up, input bit wb, input bit usr,
                     input logic [7:0] pat, input string tag);
    rec_t q[$];
    rec_t act;
    int n = $countones(list);
    int expn = (n == 0) ? 1 : 1 + n + (wb ? (ld ? 2 : 1) : 0);
    int got = 0;
    int cyc = 0;
    build(q, list, base, ld, up, wb, usr);
    @(negedge clk);
    chk(in_ready === 1'b1, {tag, " R1 ready before issue"}, 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_list = list; in_base = 4'(base);
    in_load = ld; in_up = up; in_wb = wb; in_user = usr;
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() > 0 && !done) begin
      uop_ready = pat[cyc % 8];
      cyc++;
      #1;
      act = {uop_opc, uop_dst, uop_src, uop_imm, uop_neg, uop_nonspec,
             uop_ctrl, uop_ret, uop_last};
      chk(uop_valid === 1'b1 && act === q[0], {tag, " micro-op"},
          64'({uop_valid, act}), 64'({1'b1, q[0]}));
      chk(in_ready === 1'b0, {tag, " R1 busy"}, 64'(in_ready), 64'd0);
      if (uop_ready) begin
        void'(q.pop_front());
        got++;
      end
      @(negedge clk);
    end
    uop_ready = 1'b0;
    #1;
    chk(uop_valid === 1'b0 && in_ready === 1'b1, {tag, " R12 idle after last"},
        64'({uop_valid, in_ready}), 64'b01);
    chk(got == expn, {tag, " R2 count"}, 64'(got), 64'(expn));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && uop_valid === 1'b0, "R1 reset state",
        64'({in_ready, uop_valid}), 64'b10);
    run(16'h0000, 5,  1, 1, 1, 0, 8'hFF, "R3 empty list");
    run(16'h0013, 2,  0, 1, 0, 0, 8'b10110010, "R4 R5 store up");
    run(16'h8421, 7,  0, 0, 1, 0, 8'b01101101, "R5 R6 store down wb");
    run(16'h00F0, 3,  1, 1, 1, 0, 8'b11001010, "R7 R12 load up wb");
    run(16'h9002, 13, 1, 0, 1, 0, 8'hFF, "R11 move pc stack base");
    run(16'h8004, 2,  1, 1, 1, 0, 8'b10010111, "R11 move pc other base");
    run(16'h0606, 9,  0, 1, 0, 1, 8'b11110000, "R8 user store");
    run(16'h8003, 4,  1, 1, 0, 1, 8'b10101010, "R9 exc return");
    run(16'h8100, 6,  1, 0, 1, 1, 8'b01110011, "R10 exc return wb");
    run(16'hFFFF, 0,  1, 1, 1, 0, 8'b11011011, "R2 full list");
    run(16'h6000, 1,  1, 0, 1, 1, 8'hFF, "R8 R7 user load wb");
    run(16'h0001, 15, 0, 0, 1, 0, 8'b00010001, "R6 single store down");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule